// File: doc/BRIEF.md
# Bridge Configuration Space with Interrupt Steering

This block holds the 256-byte configuration register space of a host bridge function. A byte-wide port carries an offset, write data and a write strobe. Reads are combinational: the addressed byte appears on the read-data output in the same cycle. Four identification bytes cannot be written. Two control bytes accept writes only in selected bits. Every other byte is fully writable.

Two of the bytes are routing registers. Each one packs the steering of two PCI interrupt pins, one pin per nibble. Each nibble holds a 3-bit IRQ number and an enable bit. The block decodes both registers continuously into four outputs, one for each of INTA to INTD. Each output is an IRQ number plus a valid flag, ready for the interrupt controller that sits beside the bridge.

Top module: `bridge_cfg_space`

## Requirements
- R1: Offsets 00h, 01h, 02h and 03h always read 06h, 11h, 05h and 05h, and writes to them change nothing.
- R2: Offset 04h resets to 07h. A write changes only bits 2:0, and bits 7:3 keep their stored value.
- R3: Offset 07h resets to 90h. A write changes only bits 7 and 4, and the other bits keep their stored value.
- R4: After reset, offset 81h reads 01h, 84h reads 03h and 93h reads 40h. Every byte not named in R1 to R4 reads 00h.
- R5: Every offset not named in R1 to R3 stores all 8 written bits, and a read returns the stored byte.
- R6: Register 91h steers INTA (pin 0) and INTB (pin 1). INTA takes its IRQ number from bits 2:0 and its enable from bit 3. INTB takes its IRQ number from bits 6:4 and its enable from bit 7.
- R7: Register 90h steers INTC (pin 2) and INTD (pin 3). Bits 2:0 give the INTC IRQ number and bit 3 its enable. Bits 6:4 give the INTD IRQ number and bit 7 its enable.
- R8: A pin is valid only when its enable bit is 1 and its IRQ number is non-zero. A pin that is not valid drives IRQ number 0. Pin k uses irq_num_o[3k+2:3k] and irq_valid_o[k].
- R9: While reset is active, and in the first cycle after it, all four pins are invalid.
- R10: A write to a routing register reaches the pin outputs in the cycle after the write edge. Both the enable and the IRQ number change together. A read of the written offset in the write cycle returns the old byte.
- R11: With cfg_we low, no byte and no pin output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Byte offset for reads and writes |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe, sampled on the rising edge |
| cfg_rdata | output | 8 | Stored byte at cfg_addr, combinational |
| irq_num_o | output | 12 | IRQ number for each pin, 3 bits per pin, INTA in the low bits |
| irq_valid_o | output | 4 | Valid flag for each pin, INTA in bit 0 |

## Verification
Two functions can land in the same cycle: a write to a routing register, and a read of that same offset, while the decoded pin outputs are also being observed. The bench sets up a write to 91h with the offset held on the port. It samples before the edge and expects the old byte and the old pin state. After the edge it expects the new byte, and both the enable and the IRQ number on the outputs at once. A second case writes a masked control byte and reads it back in the same cycle, so that masking and the read path are judged against each other.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam logic [7:0] OFF_CMD      = 8'h04;
  localparam logic [7:0] OFF_STAT_HI  = 8'h07;
  localparam logic [7:0] OFF_ROUTE_CD = 8'h90;
  localparam logic [7:0] OFF_ROUTE_AB = 8'h91;

  // Value a byte takes on reset.
  function automatic logic [7:0] reset_byte(input logic [7:0] off);
    case (off)
      8'h00:       reset_byte = 8'h06;
      8'h01:       reset_byte = 8'h11;
      8'h02:       reset_byte = 8'h05;
      8'h03:       reset_byte = 8'h05;
      OFF_CMD:     reset_byte = 8'h07;
      OFF_STAT_HI: reset_byte = 8'h90;
      8'h81:       reset_byte = 8'h01;
      8'h84:       reset_byte = 8'h03;
      8'h93:       reset_byte = 8'h40;
      default:     reset_byte = 8'h00;
    endcase
  endfunction

  // Bits a write may change.
  function automatic logic [7:0] write_mask(input logic [7:0] off);
    case (off)
      8'h00, 8'h01, 8'h02, 8'h03: write_mask = 8'h00;
      OFF_CMD:                    write_mask = 8'h07;
      OFF_STAT_HI:                write_mask = 8'h90;
      default:                    write_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] merge_byte(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] mask);
    merge_byte = (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata,
  output logic [7:0]        route_ab,
  output logic [7:0]        route_cd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] addr8;
  logic [7:0] cur_byte;
  logic [7:0] next_byte;

  assign addr8     = 8'(addr);
  assign cur_byte  = mem[addr];
  assign next_byte = merge_byte(cur_byte, wdata, write_mask(addr8));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reset_byte(8'(i));
    end else if (we) begin
      mem[addr] <= next_byte;
    end
  end

  assign rdata    = cur_byte;
  assign route_ab = mem[ADDR_W'(OFF_ROUTE_AB)];
  assign route_cd = mem[ADDR_W'(OFF_ROUTE_CD)];
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int IRQ_W = 3
) (
  input  logic [7:0]         route_byte,
  output logic [1:0]         pin_valid,
  output logic [2*IRQ_W-1:0] pin_num
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [IRQ_W-1:0] field;
    logic             en;
    assign field = route_byte[h*4 +: IRQ_W];
    assign en    = route_byte[h*4 + 3];
    assign pin_valid[h] = en && (field != '0);
    assign pin_num[h*IRQ_W +: IRQ_W] = pin_valid[h] ? field : '0;
  end
endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space #(
  parameter int ADDR_W   = 8,
  parameter int IRQ_W    = 3,
  parameter int NUM_PINS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [7:0]                cfg_wdata,
  input  logic                      cfg_we,
  output logic [7:0]                cfg_rdata,
  output logic [NUM_PINS*IRQ_W-1:0] irq_num_o,
  output logic [NUM_PINS-1:0]       irq_valid_o
);
  localparam int NUM_ROUTE = NUM_PINS / 2;

  logic       wr_fire;
  logic [7:0] route_ab;
  logic [7:0] route_cd;
  logic [7:0] route_bytes [NUM_ROUTE];

  assign wr_fire = cfg_we && rst_n;

  cfg_byte_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .we       (wr_fire),
    .rdata    (cfg_rdata),
    .route_ab (route_ab),
    .route_cd (route_cd)
  );

  assign route_bytes[0] = route_ab;
  assign route_bytes[1] = route_cd;

  for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_route
    irq_route_decode #(.IRQ_W(IRQ_W)) u_dec (
      .route_byte (route_bytes[r]),
      .pin_valid  (irq_valid_o[2*r +: 2]),
      .pin_num    (irq_num_o[2*r*IRQ_W +: 2*IRQ_W])
    );
  end
endmodule

// File: rtl/bridge_cfg_space_chk.sv
module bridge_cfg_space_chk #(
  parameter int ADDR_W   = 8,
  parameter int IRQ_W    = 3,
  parameter int NUM_PINS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         cfg_addr,
  input logic [7:0]                cfg_wdata,
  input logic                      cfg_we,
  input logic [7:0]                cfg_rdata,
  input logic [NUM_PINS*IRQ_W-1:0] irq_num_o,
  input logic [NUM_PINS-1:0]       irq_valid_o,
  input logic [7:0]                route_ab
);
  p_id_byte0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(0)) |-> (cfg_rdata == 8'h06));

  p_id_byte1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(1)) |-> (cfg_rdata == 8'h11));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_valid_o == '0));

  p_route_ab_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(8'h91) && cfg_wdata[3] && cfg_wdata[2:0] != 3'd0)
    |=> (irq_valid_o[0] && irq_num_o[IRQ_W-1:0] == $past(cfg_wdata[IRQ_W-1:0])));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !$past(!rst_n)) |=> ($stable(irq_valid_o) && $stable(irq_num_o) && $stable(route_ab)));

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    p_valid_has_num_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o[k] |-> (irq_num_o[k*IRQ_W +: IRQ_W] != '0));
    p_invalid_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid_o[k] |-> (irq_num_o[k*IRQ_W +: IRQ_W] == '0));
  end
endmodule

bind bridge_cfg_space bridge_cfg_space_chk #(
  .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .NUM_PINS(NUM_PINS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .cfg_we      (cfg_we),
  .cfg_rdata   (cfg_rdata),
  .irq_num_o   (irq_num_o),
  .irq_valid_o (irq_valid_o),
  .route_ab    (route_ab)
);

// File: tb/test_bridge_cfg_space.sv
module test_bridge_cfg_space;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [11:0] irq_num_o;
  logic [3:0]  irq_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bridge_cfg_space i_bridge_cfg_space (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .irq_num_o(irq_num_o),
    .irq_valid_o(irq_valid_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata, exp, req);
  endtask

  // Expected pin state for one routing byte, from the bit layout in R6/R7/R8.
  function automatic logic [3:0] exp_pin(input logic [7:0] b, input int hi);
    logic [2:0] f;
    logic       e;
    f = hi ? b[6:4] : b[2:0];
    e = hi ? b[7] : b[3];
    return (e && f != 0) ? {1'b1, f} : 4'b0000;
  endfunction

  task automatic pins_chk(input logic [7:0] ab, input logic [7:0] cd, input string req);
    logic [3:0] e0, e1, e2, e3;
    e0 = exp_pin(ab, 0); e1 = exp_pin(ab, 1);
    e2 = exp_pin(cd, 0); e3 = exp_pin(cd, 1);
    chk(irq_valid_o, {e3[3], e2[3], e1[3], e0[3]}, req);
    chk(irq_num_o, {e3[2:0], e2[2:0], e1[2:0], e0[2:0]}, req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq_valid_o, 4'h0, "R9 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_valid_o, 4'h0, "R9 after reset");
    chk(irq_num_o, 12'h0, "R9 nums after reset");
  endtask

  task automatic t_id_readonly();
    rd_chk(8'h00, 8'h06, "R1 id0"); rd_chk(8'h01, 8'h11, "R1 id1");
    rd_chk(8'h02, 8'h05, "R1 id2"); rd_chk(8'h03, 8'h05, "R1 id3");
    for (int i = 0; i < 4; i++) wr(8'(i), 8'hA5);
    rd_chk(8'h00, 8'h06, "R1 id0 after write"); rd_chk(8'h01, 8'h11, "R1 id1 after write");
    rd_chk(8'h02, 8'h05, "R1 id2 after write"); rd_chk(8'h03, 8'h05, "R1 id3 after write");
  endtask

  task automatic t_masks();
    rd_chk(8'h04, 8'h07, "R2 reset");
    wr(8'h04, 8'hF8);
    rd_chk(8'h04, 8'h00, "R2 clear low bits");
    wr(8'h04, 8'hFD);
    rd_chk(8'h04, 8'h05, "R2 high bits held");
    rd_chk(8'h07, 8'h90, "R3 reset");
    wr(8'h07, 8'h6F);
    rd_chk(8'h07, 8'h00, "R3 clear writable");
    wr(8'h07, 8'hFF);
    rd_chk(8'h07, 8'h90, "R3 only 7 and 4");
  endtask

  task automatic t_defaults();
    rd_chk(8'h81, 8'h01, "R4 81h"); rd_chk(8'h84, 8'h03, "R4 84h");
    rd_chk(8'h93, 8'h40, "R4 93h"); rd_chk(8'h05, 8'h00, "R4 05h");
    rd_chk(8'h90, 8'h00, "R4 90h"); rd_chk(8'hFF, 8'h00, "R4 FFh");
  endtask

  task automatic t_general_rw();
    wr(8'h40, 8'h5A); wr(8'hFF, 8'hC3); wr(8'h81, 8'hFE);
    rd_chk(8'h40, 8'h5A, "R5 40h"); rd_chk(8'hFF, 8'hC3, "R5 FFh");
    rd_chk(8'h81, 8'hFE, "R5 81h");
  endtask

  task automatic t_route();
    wr(8'h91, 8'hDB);   // B en irq 5, A en irq 3
    rd_chk(8'h91, 8'hDB, "R6 readback");
    pins_chk(8'hDB, 8'h00, "R6 A and B");
    wr(8'h90, 8'hEC);   // D en irq 6, C en irq 4
    pins_chk(8'hDB, 8'hEC, "R7 C and D");
    wr(8'h91, 8'h78);   // B irq 7 no enable, A enabled irq 0
    pins_chk(8'h78, 8'hEC, "R8 disabled cases");
    wr(8'h90, 8'h8F);   // D enabled irq 0, C en irq 7
    pins_chk(8'h78, 8'h8F, "R8 zero field");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_addr = 8'h91; cfg_wdata = 8'h9A; cfg_we = 1'b1;
    #1;
    chk(cfg_rdata, 8'h78, "R10 old byte in write cycle");
    pins_chk(8'h78, 8'h8F, "R10 old pins in write cycle");
    @(posedge clk); #1;
    cfg_we = 1'b0;
    chk(cfg_rdata, 8'h9A, "R10 new byte after edge");
    pins_chk(8'h9A, 8'h8F, "R10 enable and irq together");
    @(negedge clk);
    cfg_addr = 8'h04; cfg_wdata = 8'h02; cfg_we = 1'b1;
    #1;
    chk(cfg_rdata, 8'h05, "R10 masked old byte");
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata, 8'h02, "R2 masked new byte");
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    cfg_addr = 8'h91; cfg_wdata = 8'h00; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg_rdata, 8'h9A, "R11 byte unchanged");
    pins_chk(8'h9A, 8'h8F, "R11 pins unchanged");
  endtask

  initial begin
    t_reset();
    t_id_readonly();
    t_masks();
    t_defaults();
    t_general_rw();
    t_route();
    t_same_cycle();
    t_no_strobe();
    t_reset();
    rd_chk(8'h91, 8'h00, "R4 91h after second reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule